// File: doc/BRIEF.md
# Receive Queue with Character-Time Timeout

This block is the receive side of a 16550-compatible serial port, placed between the deserialiser and the register bus. Received bytes arrive with a one-cycle valid strobe and are placed in a first-in first-out buffer of `DEPTH` entries. A line break also arrives as a one-cycle strobe and is stored as a zero byte. The CPU takes bytes out with a one-cycle receive-buffer read strobe. The block reports data ready, overrun and break status, the fill level, whether the programmed trigger level has been reached, and whether a receive timeout is pending.

The buffer is configured through a byte written to the FIFO control register. Its enable bit chooses between queued operation and a single holding register that behaves like the original 8250. The line-format bits of the line control register set the length of one serial character. That length is counted in baud ticks and gives the timeout window.

Each strobe is sampled on a rising clock edge. All status outputs are registered and change on that same edge. Read data is visible after the edge that took the read strobe.

Top module: `uart_rxq`

## Requirements
- R1: After synchronous reset, data_ready, overrun, break_ind, trig_hit and tmo_pend are 0, fill_count is 0 and fcr_state is 0x00, which means single-register mode.
- R2: A control write whose value differs from fcr_state stores the value ANDed with 0xC9, keeping bits 7:6, 3 and 0. A write equal to fcr_state has no effect. Any change of bit 0 (queue enable) empties the queue and clears data_ready, break_ind and tmo_pend, as does a write with bit 1 set.
- R3: In queued mode bytes are read back in arrival order. fill_count goes up by one per stored byte and down by one per read. A read of an empty queue returns 0x00.
- R4: A byte or break arriving while fill_count equals DEPTH is discarded, sets overrun, and leaves the stored bytes and fill_count unchanged.
- R5: In queued mode data_ready is 1 exactly when fill_count is non-zero. The read that removes the last byte clears both data_ready and break_ind.
- R6: trig_hit is 1 in queued mode when fill_count is at least the level selected by fcr_state[7:6]: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14.
- R7: One character is 7 + lcr_fmt[1:0] + lcr_fmt[3] + lcr_fmt[2] bits, and each bit lasts BIT_TICKS baud ticks. A timer is loaded with four character times by every stored or discarded arrival in queued mode. tmo_pend rises on the tick that empties the timer, but only if the queue is not empty at that moment.
- R8: Every receive-buffer read clears tmo_pend. A read that leaves bytes behind reloads the full four-character window.
- R9: A break strobe stores a 0x00 byte, subject to R4, and sets both break_ind and data_ready.
- R10: An LSR read strobe clears break_ind and overrun unless a new event sets them in the same cycle.
- R11: In single-register mode a new byte replaces the held byte. If data_ready was still set, overrun is raised. A read returns the byte held before the read edge and clears data_ready. fill_count, trig_hit and tmo_pend stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per baud tick; paces the timeout timer |
| rx_valid | input | 1 | A received byte is on rx_data this cycle |
| rx_data | input | DW | Received byte |
| rx_break | input | 1 | A line break was detected this cycle |
| rbr_rd | input | 1 | CPU read of the receive buffer |
| lsr_rd | input | 1 | CPU read of the line status register |
| fcr_wr | input | 1 | CPU write of the FIFO control register |
| fcr_data | input | 8 | Value written to the FIFO control register |
| lcr_fmt | input | 4 | Line-format bits: [1:0] word length code, [2] two stop bits, [3] parity present |
| rd_data | output | DW | Byte returned by the most recent receive-buffer read |
| data_ready | output | 1 | Received data is available |
| overrun | output | 1 | A byte was lost |
| break_ind | output | 1 | A break was received |
| fill_count | output | $clog2(DEPTH+1) | Number of queued bytes |
| trig_hit | output | 1 | The fill level has reached the trigger level |
| tmo_pend | output | 1 | The character timeout has expired with data queued |
| fcr_state | output | 8 | Stored control byte |

## Verification
The assertions assume that a control write never shares a cycle with a received byte, break or read. A write that changes the control byte wins over those events, and the counting properties do not model that overlap. They also assume that a break strobe and rx_valid are never raised together. The bench drives one strobe per cycle through tasks that always return the strobe to zero, so both assumptions hold. The timeout sweep covers all sixteen line formats. It counts the exact number of baud ticks before the window expires and applies no ticks anywhere else.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  localparam int FCR_EN    = 0;
  localparam int FCR_RXRST = 1;
  localparam logic [7:0] FCR_KEEP = 8'hC9;
  localparam int MAX_FRAME = 12;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // start + data(5..8) + parity + stop(1..2)
  function automatic int unsigned frame_bits(input logic [3:0] fmt);
    return 32'd7 + 32'(fmt[1:0]) + 32'(fmt[3]) + 32'(fmt[2]);
  endfunction

endpackage

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/uart_rxq_tmo.sv
module uart_rxq_tmo
  import uart_rxq_pkg::*;
#(
  parameter int BIT_TICKS = 1,
  localparam int LIMIT_MAX = 4 * MAX_FRAME * BIT_TICKS,
  localparam int CNTW = $clog2(LIMIT_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       arm,
  input  logic       rd_clr,
  input  logic       baud_tick,
  input  logic [3:0] frame_fmt,
  input  logic       nonempty,
  output logic       pend
);

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] limit;
  logic            run_q;
  logic            expire;

  assign limit  = CNTW'(4 * frame_bits(frame_fmt) * BIT_TICKS);
  assign expire = run_q && baud_tick && !arm && (cnt_q == CNTW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (arm) begin
        cnt_q <= limit;
        run_q <= 1'b1;
      end else if (run_q && baud_tick) begin
        if (expire) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CNTW'(1);
        end
      end
      if (rd_clr)                 pend <= 1'b0;
      else if (expire && nonempty) pend <= 1'b1;
    end
  end

  // R7: pending only ever seen with bytes queued
  a_r7_pend_needs_data: assert property (@(posedge clk) disable iff (rst)
    pend |-> nonempty);

  // R7: pending rises only on a baud tick
  a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(baud_tick));

  // R8: a buffer read always drops pending
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> !pend);

endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rbr_rd,
  input  logic          lsr_rd,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          tmo_clr,
  output logic          tmo_arm,
  output logic          tmo_rd,
  output logic          nonempty,
  output logic [DW-1:0] rd_data,
  output logic          data_ready,
  output logic          overrun,
  output logic          break_ind,
  output logic [CW-1:0] fill_count,
  output logic          trig_hit,
  output logic [7:0]    fcr_state
);

  logic [7:0]    fcr_q, fcr_n;
  logic [CW-1:0] count_q, count_n;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          dr_q, dr_n, bi_q, bi_n, oe_q, oe_n;
  logic [DW-1:0] hold_q, rd_hold_q, in_byte;
  logic          rd_fifo_q, rd_zero_q;
  logic          fcr_change, mode_flip, rx_reset, fifo_mode;
  logic          in_evt, rd_evt, full, push, pop, ovf, trig_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    fcr_change = fcr_wr && (fcr_data != fcr_q);
    mode_flip  = fcr_change && (fcr_data[FCR_EN] != fcr_q[FCR_EN]);
    rx_reset   = fcr_change && (fcr_data[FCR_RXRST] || mode_flip);
    fcr_n      = fcr_change ? (fcr_data & FCR_KEEP) : fcr_q;
    fifo_mode  = fcr_q[FCR_EN];
    in_evt     = !fcr_change && (rx_valid || rx_break);
    in_byte    = rx_break ? '0 : rx_data;
    rd_evt     = !fcr_change && rbr_rd;
    full       = (count_q == CW'(DEPTH));
    push       = in_evt && fifo_mode && !full;
    pop        = rd_evt && fifo_mode && (count_q != '0);
    ovf        = in_evt && (fifo_mode ? full : (dr_q && !rd_evt));

    if (rx_reset) count_n = '0;
    else          count_n = count_q + CW'(push) - CW'(pop);

    if (rx_reset)       dr_n = 1'b0;
    else if (fifo_mode) dr_n = (count_n != '0);
    else if (in_evt)    dr_n = 1'b1;
    else if (rd_evt)    dr_n = 1'b0;
    else                dr_n = dr_q;

    if (rx_reset)                    bi_n = 1'b0;
    else if (in_evt && rx_break)     bi_n = 1'b1;
    else if (lsr_rd)                 bi_n = 1'b0;
    else if (rd_evt && (!fifo_mode || count_n == '0)) bi_n = 1'b0;
    else                             bi_n = bi_q;

    if (ovf)         oe_n = 1'b1;
    else if (lsr_rd) oe_n = 1'b0;
    else             oe_n = oe_q;

    trig_n = fcr_n[FCR_EN] && (count_n >= CW'(trig_level(fcr_n[7:6])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcr_q     <= '0;
      count_q   <= '0;
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      dr_q      <= 1'b0;
      bi_q      <= 1'b0;
      oe_q      <= 1'b0;
      hold_q    <= '0;
      rd_hold_q <= '0;
      rd_fifo_q <= 1'b0;
      rd_zero_q <= 1'b0;
      trig_hit  <= 1'b0;
    end else begin
      fcr_q    <= fcr_n;
      count_q  <= count_n;
      dr_q     <= dr_n;
      bi_q     <= bi_n;
      oe_q     <= oe_n;
      trig_hit <= trig_n;
      if (rx_reset) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push) wr_ptr_q <= bump(wr_ptr_q);
        if (pop)  rd_ptr_q <= bump(rd_ptr_q);
      end
      if (in_evt && !fifo_mode) hold_q <= in_byte;
      if (rd_evt) begin
        rd_fifo_q <= fifo_mode;
        rd_zero_q <= (count_q == '0);
        rd_hold_q <= hold_q;
      end
    end
  end

  assign mem_we     = push;
  assign mem_waddr  = wr_ptr_q;
  assign mem_wdata  = in_byte;
  assign mem_re     = pop;
  assign mem_raddr  = rd_ptr_q;
  assign tmo_clr    = rx_reset;
  assign tmo_arm    = fifo_mode && (in_evt || (pop && count_n != '0));
  assign tmo_rd     = rd_evt;
  assign nonempty   = (count_q != '0);
  assign rd_data    = rd_fifo_q ? (rd_zero_q ? '0 : mem_rdata) : rd_hold_q;
  assign data_ready = dr_q;
  assign overrun    = oe_q;
  assign break_ind  = bi_q;
  assign fill_count = count_q;
  assign fcr_state  = fcr_q;

  // R4: arrival into a full queue keeps the level and flags overrun
  a_r4_full_overrun: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && full && in_evt && !rbr_rd) |=> (oe_q && count_q == CW'(DEPTH)));

  // R2: receive reset bit always leaves an empty queue
  a_r2_rx_reset_empties: assert property (@(posedge clk) disable iff (rst)
    (fcr_wr && fcr_data[FCR_RXRST]) |=> (count_q == '0 && !dr_q));

  // R5: data ready mirrors a non-zero level in queued mode
  a_r5_ready_matches_level: assert property (@(posedge clk) disable iff (rst)
    fcr_q[FCR_EN] |-> (dr_q == (count_q != '0)));

  // R10: status read with no new event clears both sticky bits
  a_r10_lsr_clears: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !rx_valid && !rx_break) |=> (!bi_q && !oe_q));

  // R3: level never exceeds capacity
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int BIT_TICKS = 1,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  input  logic          rbr_rd,
  input  logic          lsr_rd,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_data,
  input  logic [3:0]    lcr_fmt,
  output logic [DW-1:0] rd_data,
  output logic          data_ready,
  output logic          overrun,
  output logic          break_ind,
  output logic [CW-1:0] fill_count,
  output logic          trig_hit,
  output logic          tmo_pend,
  output logic [7:0]    fcr_state
);

  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          tmo_clr, tmo_arm, tmo_rd, nonempty;

  uart_rxq_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .tmo_clr(tmo_clr), .tmo_arm(tmo_arm), .tmo_rd(tmo_rd), .nonempty(nonempty),
    .rd_data(rd_data), .data_ready(data_ready), .overrun(overrun),
    .break_ind(break_ind), .fill_count(fill_count), .trig_hit(trig_hit),
    .fcr_state(fcr_state)
  );

  uart_rxq_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  uart_rxq_tmo #(.BIT_TICKS(BIT_TICKS)) u_tmo (
    .clk(clk), .rst(rst), .clr(tmo_clr), .arm(tmo_arm), .rd_clr(tmo_rd),
    .baud_tick(baud_tick), .frame_fmt(lcr_fmt), .nonempty(nonempty),
    .pend(tmo_pend)
  );

endmodule

// File: tb/sim_uart_rxq.sv
module sim_uart_rxq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst, baud_tick, rx_valid, rx_break, rbr_rd, lsr_rd, fcr_wr;
  logic [DW-1:0] rx_data;
  logic [7:0]    fcr_data;
  logic [3:0]    lcr_fmt;
  logic [DW-1:0] rd_data;
  logic          data_ready, overrun, break_ind, trig_hit, tmo_pend;
  logic [CW-1:0] fill_count;
  logic [7:0]    fcr_state;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 0;

  uart_rxq #(.DW(DW), .DEPTH(DEPTH), .BIT_TICKS(1)) u0 (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_break(rx_break), .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
    .fcr_wr(fcr_wr), .fcr_data(fcr_data), .lcr_fmt(lcr_fmt), .rd_data(rd_data),
    .data_ready(data_ready), .overrun(overrun), .break_ind(break_ind),
    .fill_count(fill_count), .trig_hit(trig_hit), .tmo_pend(tmo_pend),
    .fcr_state(fcr_state)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b; @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic brk();
    rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
  endtask
  task automatic rd();
    rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0;
  endtask
  task automatic lsr();
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
  endtask
  task automatic fcr(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_data = v; @(negedge clk); fcr_wr = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1'b1; @(negedge clk);
    end
    baud_tick = 1'b0;
  endtask

  function automatic int frame_len(input logic [3:0] f);
    return 7 + int'(f[1:0]) + int'(f[3]) + int'(f[2]);
  endfunction

  function automatic logic [7:0] pat(input int lvl, input int i);
    return 8'((lvl * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lim;
    rst = 1'b1; baud_tick = 0; rx_valid = 0; rx_break = 0; rbr_rd = 0;
    lsr_rd = 0; fcr_wr = 0; rx_data = '0; fcr_data = '0; lcr_fmt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 dr", data_ready, 0);
    chk("R1 oe", overrun, 0);
    chk("R1 bi", break_ind, 0);
    chk("R1 fill", fill_count, 0);
    chk("R1 trig", trig_hit, 0);
    chk("R1 tmo", tmo_pend, 0);
    chk("R1 fcr", fcr_state, 0);

    fcr(8'h01);
    chk("R2 enable stored", fcr_state, 8'h01);
    fcr(8'hFF);
    chk("R2 masked store", fcr_state, 8'hC9);

    // R3/R4/R5/R6 sweep over every trigger level and every fill level
    for (int lvl = 0; lvl < 4; lvl++) begin
      int tl;
      tl = (lvl == 0) ? 1 : (lvl == 1) ? 4 : (lvl == 2) ? 8 : 14;
      fcr(8'(lvl << 6) | 8'h03);
      chk("R2 level stored", fcr_state, 8'(lvl << 6) | 8'h01);
      chk("R2 reset empties", fill_count, 0);
      for (int i = 0; i < DEPTH; i++) begin
        push(pat(lvl, i));
        chk("R3 fill up", fill_count, i + 1);
        chk("R6 trigger", trig_hit, (i + 1 >= tl) ? 1 : 0);
        chk("R5 dr set", data_ready, 1);
      end
      push(8'hEE);
      chk("R4 overrun", overrun, 1);
      chk("R4 fill held", fill_count, DEPTH);
      lsr();
      chk("R10 oe cleared", overrun, 0);
      for (int i = 0; i < DEPTH; i++) begin
        rd();
        chk("R3 order", rd_data, pat(lvl, i));
        chk("R3 fill down", fill_count, DEPTH - 1 - i);
        chk("R5 dr", data_ready, (i < DEPTH - 1) ? 1 : 0);
      end
      rd();
      chk("R3 empty read zero", rd_data, 0);
      chk("R3 empty fill", fill_count, 0);
    end

    // R2 identical write ignored
    push(8'h55);
    fcr(8'hC1);
    chk("R2 identical ignored", fill_count, 1);
    rd();
    chk("R2 data kept", rd_data, 8'h55);

    // R9 break, R10 status read
    brk();
    chk("R9 fill", fill_count, 1);
    chk("R9 bi", break_ind, 1);
    chk("R9 dr", data_ready, 1);
    lsr();
    chk("R10 bi cleared", break_ind, 0);
    chk("R10 dr kept", data_ready, 1);
    rd();
    chk("R9 zero byte", rd_data, 0);
    brk();
    rd();
    chk("R5 last read clears bi", break_ind, 0);
    chk("R5 last read clears dr", data_ready, 0);

    // R7 timeout window over all line formats
    for (int f = 0; f < 16; f++) begin
      lcr_fmt = 4'(f);
      lim = 4 * frame_len(4'(f));
      push(8'hA0 + 8'(f));
      ticks(lim - 1);
      chk("R7 not early", tmo_pend, 0);
      ticks(1);
      chk("R7 expires", tmo_pend, 1);
      rd();
      chk("R8 read clears", tmo_pend, 0);
      chk("R7 data", rd_data, 8'hA0 + 8'(f));
    end

    // R8 reload by a read that leaves data
    lim = 4 * frame_len(lcr_fmt);
    push(8'h01);
    push(8'h02);
    ticks(lim - 1);
    chk("R8 pre", tmo_pend, 0);
    rd();
    ticks(lim - 1);
    chk("R8 reloaded", tmo_pend, 0);
    ticks(1);
    chk("R8 expires after reload", tmo_pend, 1);
    fcr(8'hC3);
    chk("R2 reset clears tmo", tmo_pend, 0);
    chk("R2 reset fill", fill_count, 0);

    // R7 expiry with empty queue stays low
    push(8'h09);
    rd();
    ticks(lim);
    chk("R7 empty no pend", tmo_pend, 0);

    // R2 mode flip empties
    push(8'h10);
    push(8'h20);
    fcr(8'hC0);
    chk("R2 flip stored", fcr_state, 8'hC0);
    chk("R2 flip fill", fill_count, 0);
    chk("R2 flip dr", data_ready, 0);

    // R11 single holding register
    push(8'h11);
    chk("R11 dr", data_ready, 1);
    chk("R11 no oe", overrun, 0);
    push(8'h22);
    chk("R11 oe", overrun, 1);
    chk("R11 fill zero", fill_count, 0);
    chk("R11 trig zero", trig_hit, 0);
    rd();
    chk("R11 latest byte", rd_data, 8'h22);
    chk("R11 dr cleared", data_ready, 0);
    lsr();
    chk("R10 oe cleared single", overrun, 0);
    push(8'h33);
    ticks(60);
    chk("R11 no timeout", tmo_pend, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule